// File: doc/BRIEF.md
# Dual-Channel Data-Ready Pulse Combiner

This block sits between two sigma-delta conversion channels and a host. Each channel presents a one-cycle completion strobe along with a 24-bit sample, plus a reset flag and a shutdown flag. The block drives one active-low data-ready pin and two output sample registers that the host reads. A 2-bit selection input decides which channel's completions reach the pin. In the linked selection both channels act as a single two-lane channel. A pulse is issued only once each channel has produced a fresh sample, and both output registers load at that moment.

The linked selection is a three-state machine: `LK_EMPTY` means no fresh sample is held. `LK_HAVE0` means channel 0 has reported and the block waits for channel 1. `LK_HAVE1` is the mirror case. From `LK_EMPTY`, a strobe from a single channel moves to the matching waiting state, and simultaneous strobes fire at once and stay in `LK_EMPTY`. From a waiting state, a strobe from the other channel fires and returns to `LK_EMPTY`. A repeated strobe from the same channel stays put and keeps the newer sample. Any of the following forces `LK_EMPTY` without firing: the selection is not linked, the selection changed this cycle, or either channel is asleep.

The pin is shaped by a two-state machine. `PL_IDLE` holds the pin high. A fire moves it to `PL_LOW`, which holds the pin low for `PULSE_LEN` cycles. A fire during `PL_LOW` restarts the count, and the count reaching zero returns to `PL_IDLE`.

Top module: `drdy_combiner`

## Requirements
- R1: After reset, `drdy_n` is 1, both output registers are 0, the selection register holds 00, and no fresh sample is held.
- R2: A fire makes `drdy_n` low from the cycle after the triggering strobe edge for exactly `PULSE_LEN` cycles. Strobes from both channels in the same cycle give one pulse, and a fire during a pulse restarts the full length.
- R3: With `sel` = 11, a strobe from either awake channel fires the pin.
- R4: With `sel` = 10, only channel 1 strobes fire the pin, and channel 0 strobes do not.
- R5: With `sel` = 01, only channel 0 strobes fire the pin, and channel 1 strobes do not.
- R6: With `sel` = 00 (the reset value), a pulse fires in the cycle of the strobe that completes a pair of fresh samples, one from each channel, in either order. No pulse is issued for the earlier strobe.
- R7: In `sel` = 00, both output registers load together on the completing strobe. The leading channel's value is the newest sample it strobed since the last pulse.
- R8: In `sel` = 00, no pulse fires while either channel has `rst` or `shdn` set, and any fresh sample held is discarded.
- R9: A strobe from a channel whose `rst` or `shdn` is set is ignored in every selection: it causes no pulse and no register change. With `sel` = 11, the awake channel still fires normally.
- R10: With `sel` = 01, 10 or 11, each awake channel's output register loads on its own strobe, even when that strobe is kept off the pin.
- R11: A change of `sel` discards any held sample. A strobe in the cycle `sel` changes to 00 is dropped. A strobe in a cycle that changes to a non-00 value acts normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 2 | Pin source selection: 00 linked, 01 channel 0, 10 channel 1, 11 both |
| c0_stb | input | 1 | Channel 0 conversion-complete strobe |
| c0_smp | input | DW | Channel 0 sample |
| c0_rst | input | 1 | Channel 0 held in reset |
| c0_shdn | input | 1 | Channel 0 shut down |
| c1_stb | input | 1 | Channel 1 conversion-complete strobe |
| c1_smp | input | DW | Channel 1 sample |
| c1_rst | input | 1 | Channel 1 held in reset |
| c1_shdn | input | 1 | Channel 1 shut down |
| drdy_n | output | 1 | Active-low data-ready pin |
| out0 | output | DW | Channel 0 output register |
| out1 | output | DW | Channel 1 output register |

## Verification
A wrong link state shows up on the pin at the next strobe of either channel. A lost fresh flag delays the pulse by one full pair, and a stale one fires a pulse a sample early with a mismatched pair in the output registers. Either fault is visible in that same cycle. A wrong pulse counter appears within `PULSE_LEN` cycles as a pulse that is too short or too long. The bench compares the pin and both registers against a behavioural model on every cycle, so each fault is reported in the first cycle it reaches a port.

// File: rtl/drdy_pkg.sv
package drdy_pkg;
    typedef enum logic [1:0] {
        SEL_LINKED = 2'b00,
        SEL_CH0    = 2'b01,
        SEL_CH1    = 2'b10,
        SEL_BOTH   = 2'b11
    } sel_mode_e;

    typedef enum logic [1:0] {
        LK_EMPTY = 2'd0,
        LK_HAVE0 = 2'd1,
        LK_HAVE1 = 2'd2
    } link_state_e;

    typedef enum logic {
        PL_IDLE = 1'b0,
        PL_LOW  = 1'b1
    } pulse_state_e;
endpackage

// File: rtl/drdy_link.sv
module drdy_link
    import drdy_pkg::*;
#(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          awake0,
    input  logic          awake1,
    input  logic          stb0,
    input  logic          stb1,
    input  logic [DW-1:0] d0,
    input  logic [DW-1:0] d1,
    output logic          fire,
    output logic [DW-1:0] val0,
    output logic [DW-1:0] val1
);
    link_state_e state, state_nx;
    logic [DW-1:0] hold0, hold1;
    logic          live;

    assign live = enable && awake0 && awake1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LK_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold0 <= '0;
            hold1 <= '0;
        end else if (live) begin
            if (stb0) hold0 <= d0;
            if (stb1) hold1 <= d1;
        end
    end

    always_comb begin
        state_nx = state;
        fire     = 1'b0;
        if (!live) begin
            state_nx = LK_EMPTY;
        end else begin
            unique case (state)
                LK_EMPTY: begin
                    if (stb0 && stb1) fire = 1'b1;
                    else if (stb0)    state_nx = LK_HAVE0;
                    else if (stb1)    state_nx = LK_HAVE1;
                end
                LK_HAVE0: begin
                    if (stb1) begin
                        fire     = 1'b1;
                        state_nx = LK_EMPTY;
                    end
                end
                LK_HAVE1: begin
                    if (stb0) begin
                        fire     = 1'b1;
                        state_nx = LK_EMPTY;
                    end
                end
                default: state_nx = LK_EMPTY;
            endcase
        end
    end

    assign val0 = stb0 ? d0 : hold0;
    assign val1 = stb1 ? d1 : hold1;

    // R6: a completed pair always leaves the machine empty
    a_r6_fire_empties: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (state == LK_EMPTY));
    // R8: a sleeping channel never lets the pair stay held
    a_r8_sleep_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!awake0 || !awake1) |=> (state == LK_EMPTY));
endmodule

// File: rtl/drdy_pulse.sv
module drdy_pulse
    import drdy_pkg::*;
#(
    parameter int LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic drdy_n
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LOAD = CW'(LEN - 1);

    pulse_state_e state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PL_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                PL_IDLE: begin
                    if (fire) begin
                        state <= PL_LOW;
                        cnt   <= LOAD;
                    end
                end
                PL_LOW: begin
                    if (fire)          cnt   <= LOAD;
                    else if (cnt == 0) state <= PL_IDLE;
                    else               cnt   <= cnt - 1'b1;
                end
                default: state <= PL_IDLE;
            endcase
        end
    end

    always_comb begin
        drdy_n = (state != PL_LOW);
    end

    // R2: pin goes low right after a fire
    a_r2_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !drdy_n);
    // R2: expired count without a new fire releases the pin
    a_r2_pulse_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PL_LOW && cnt == 0 && !fire) |=> drdy_n);
endmodule

// File: rtl/drdy_combiner.sv
module drdy_combiner
    import drdy_pkg::*;
#(
    parameter int DW        = 24,
    parameter int PULSE_LEN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    sel,
    input  logic          c0_stb,
    input  logic [DW-1:0] c0_smp,
    input  logic          c0_rst,
    input  logic          c0_shdn,
    input  logic          c1_stb,
    input  logic [DW-1:0] c1_smp,
    input  logic          c1_rst,
    input  logic          c1_shdn,
    output logic          drdy_n,
    output logic [DW-1:0] out0,
    output logic [DW-1:0] out1
);
    sel_mode_e     sel_q;
    logic          awake0, awake1, stb0, stb1;
    logic          linked, link_en, link_fire, solo_fire, fire;
    logic [DW-1:0] link_val0, link_val1;

    assign awake0  = !c0_rst && !c0_shdn;
    assign awake1  = !c1_rst && !c1_shdn;
    assign stb0    = c0_stb && awake0;
    assign stb1    = c1_stb && awake1;
    assign linked  = (sel_mode_e'(sel) == SEL_LINKED);
    assign link_en = linked && (sel_q == SEL_LINKED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= SEL_LINKED;
        else        sel_q <= sel_mode_e'(sel);
    end

    drdy_link #(.DW(DW)) u_link (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (link_en),
        .awake0 (awake0),
        .awake1 (awake1),
        .stb0   (stb0),
        .stb1   (stb1),
        .d0     (c0_smp),
        .d1     (c1_smp),
        .fire   (link_fire),
        .val0   (link_val0),
        .val1   (link_val1)
    );

    assign solo_fire = !linked && ((stb0 && sel[0]) || (stb1 && sel[1]));
    assign fire      = link_fire || solo_fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out0 <= '0;
            out1 <= '0;
        end else if (link_fire) begin
            out0 <= link_val0;
            out1 <= link_val1;
        end else if (!linked) begin
            if (stb0) out0 <= c0_smp;
            if (stb1) out1 <= c1_smp;
        end
    end

    drdy_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .drdy_n (drdy_n)
    );

    // R4: channel 0 alone never fires in selection 10
    a_r4_ch0_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b10 && !c1_stb) |-> !fire);
    // R5: channel 1 alone never fires in selection 01
    a_r5_ch1_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b01 && !c0_stb) |-> !fire);
    // R7: both registers load from the pair on a linked fire
    a_r7_pair_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        link_fire |=> (out0 == $past(link_val0) && out1 == $past(link_val1)));
    // R8: linked selection stays quiet while any channel sleeps
    a_r8_no_fire_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        (linked && (!awake0 || !awake1)) |-> !fire);
    // R9: a sleeping channel's register never changes
    a_r9_sleep_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !awake0 |=> $stable(out0));
    // R11: no linked fire in the cycle the selection changes
    a_r11_change_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_mode_e'(sel) != sel_q) |-> !link_fire);
endmodule

// File: tb/test_drdy_combiner.sv
`timescale 1ns/1ps
module test_drdy_combiner;
    localparam int DW = 24;
    localparam int PL = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    sel = 2'b00;
    logic          c0_stb = 0, c0_rst = 0, c0_shdn = 0;
    logic          c1_stb = 0, c1_rst = 0, c1_shdn = 0;
    logic [DW-1:0] c0_smp = '0, c1_smp = '0;
    logic          drdy_n;
    logic [DW-1:0] out0, out1;

    always #4 clk = ~clk;

    drdy_combiner #(.DW(DW), .PULSE_LEN(PL)) i_drdy_combiner (
        .clk(clk), .rst_n(rst_n), .sel(sel),
        .c0_stb(c0_stb), .c0_smp(c0_smp), .c0_rst(c0_rst), .c0_shdn(c0_shdn),
        .c1_stb(c1_stb), .c1_smp(c1_smp), .c1_rst(c1_rst), .c1_shdn(c1_shdn),
        .drdy_n(drdy_n), .out0(out0), .out1(out1)
    );

    int checks = 0, failures = 0;
    bit done = 0;
    string cur = "R1";

    // behavioural reference
    bit            m_p0 = 0, m_p1 = 0;
    logic [DW-1:0] m_h0 = '0, m_h1 = '0, m_o0 = '0, m_o1 = '0;
    logic [1:0]    m_prev = 2'b00;
    int            m_low = 0;

    always @(posedge clk) begin
        bit a0, a1, s0, s1, f;
        if (!rst_n) begin
            m_p0 = 0; m_p1 = 0; m_h0 = '0; m_h1 = '0;
            m_o0 = '0; m_o1 = '0; m_prev = 2'b00; m_low = 0;
        end else begin
            a0 = !c0_rst && !c0_shdn;
            a1 = !c1_rst && !c1_shdn;
            s0 = c0_stb && a0;
            s1 = c1_stb && a1;
            f  = 0;
            if (sel == 2'b00 && m_prev == 2'b00) begin
                if (!a0 || !a1) begin
                    m_p0 = 0; m_p1 = 0;
                end else begin
                    if (s0) begin m_h0 = c0_smp; m_p0 = 1; end
                    if (s1) begin m_h1 = c1_smp; m_p1 = 1; end
                    if (m_p0 && m_p1) begin
                        f = 1; m_o0 = m_h0; m_o1 = m_h1; m_p0 = 0; m_p1 = 0;
                    end
                end
            end else begin
                m_p0 = 0; m_p1 = 0;
                if (sel != 2'b00) begin
                    if (s0) m_o0 = c0_smp;
                    if (s1) m_o1 = c1_smp;
                    f = (s0 && sel[0]) || (s1 && sel[1]);
                end
            end
            if (f) m_low = PL;
            else if (m_low > 0) m_low = m_low - 1;
            m_prev = sel;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        chk({cur, " drdy_n"}, 32'(drdy_n), 32'(m_low == 0));
        chk({cur, " out0"}, 32'(out0), 32'(m_o0));
        chk({cur, " out1"}, 32'(out1), 32'(m_o1));
    endtask

    task automatic stb(input bit s0, input bit s1, input logic [DW-1:0] d0, input logic [DW-1:0] d1);
        c0_stb = s0; c1_stb = s1; c0_smp = d0; c1_smp = d1;
        cyc();
        c0_stb = 0; c1_stb = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur = "R1";
        chk("R1 reset drdy_n", 32'(drdy_n), 32'd1);
        chk("R1 reset out0", 32'(out0), 32'd0);
        chk("R1 reset out1", 32'(out1), 32'd0);
        rst_n = 1;
        idle(3);

        cur = "R6";                       // ch0 leads, ch1 lags
        stb(1, 0, 24'h111111, 0);
        chk("R6 no pulse on leading strobe", 32'(drdy_n), 32'd1);
        idle(3);
        stb(0, 1, 0, 24'h222222);
        chk("R6 pulse on lagging strobe", 32'(drdy_n), 32'd0);
        chk("R7 out0 pair", 32'(out0), 32'h111111);
        chk("R7 out1 pair", 32'(out1), 32'h222222);
        idle(4);
        stb(0, 1, 0, 24'h333333);        // ch1 leads now
        idle(2);
        stb(1, 0, 24'h444444, 0);
        chk("R6 reversed order pulse", 32'(drdy_n), 32'd0);
        idle(4);
        cur = "R7";                       // newest leading sample kept
        stb(1, 0, 24'h000aaa, 0);
        stb(1, 0, 24'h000bbb, 0);
        stb(0, 1, 0, 24'h000ccc);
        chk("R7 newest leading", 32'(out0), 32'h000bbb);
        idle(4);

        cur = "R2";
        sel = 2'b11;
        idle(2);
        begin
            int lows = 0;
            stb(1, 1, 24'h5, 24'h6);
            if (!drdy_n) lows++;
            for (int i = 0; i < 6; i++) begin cyc(); if (!drdy_n) lows++; end
            chk("R2 coincident single pulse length", 32'(lows), 32'(PL));
        end
        stb(1, 0, 24'h7, 0);
        stb(0, 1, 0, 24'h8);              // retrigger
        idle(5);

        cur = "R3";
        stb(1, 0, 24'h10, 0); idle(3);
        stb(0, 1, 0, 24'h20); idle(3);
        cur = "R4";
        sel = 2'b10; idle(2);
        stb(1, 0, 24'h30, 0);
        chk("R4 ch0 suppressed", 32'(drdy_n), 32'd1);
        chk("R10 ch0 reg loads", 32'(out0), 32'h30);
        idle(2);
        stb(0, 1, 0, 24'h40); idle(3);
        cur = "R5";
        sel = 2'b01; idle(2);
        stb(0, 1, 0, 24'h50);
        chk("R5 ch1 suppressed", 32'(drdy_n), 32'd1);
        chk("R10 ch1 reg loads", 32'(out1), 32'h50);
        idle(2);
        stb(1, 0, 24'h60, 0); idle(3);

        cur = "R8";
        sel = 2'b00; idle(2);
        stb(1, 0, 24'h70, 0);
        c1_shdn = 1; idle(1); c1_shdn = 0;
        stb(0, 1, 0, 24'h80);
        chk("R8 held sample discarded", 32'(drdy_n), 32'd1);
        stb(1, 0, 24'h90, 0);
        chk("R8 pair after wake", 32'(drdy_n), 32'd0);
        idle(3);
        c0_rst = 1;
        stb(1, 1, 24'h91, 24'h92);
        chk("R8 no pulse in reset", 32'(drdy_n), 32'd1);
        c0_rst = 0; idle(2);

        cur = "R9";
        sel = 2'b11; c1_rst = 1; idle(2);
        stb(1, 0, 24'hA0, 0);
        chk("R9 awake ch0 pulses", 32'(drdy_n), 32'd0);
        idle(3);
        stb(0, 1, 0, 24'hB0);
        chk("R9 sleeping ch1 ignored", 32'(out1), 32'(m_o1));
        c1_rst = 0; idle(3);

        cur = "R11";
        sel = 2'b00; idle(2);
        stb(1, 0, 24'hC0, 0);
        sel = 2'b11; idle(1);
        sel = 2'b00; idle(2);
        stb(0, 1, 0, 24'hD0);
        chk("R11 change discards held", 32'(drdy_n), 32'd1);
        idle(3);

        cur = "R3/R6 random";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 99) == 0) sel = 2'($urandom);
            c0_shdn = ($urandom_range(0, 49) == 0);
            c1_rst  = ($urandom_range(0, 49) == 0);
            stb($urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
                DW'($urandom), DW'($urandom));
        end
        c0_shdn = 0; c1_rst = 0;
        idle(4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule